// File: doc/BRIEF.md
# Nibble-Accessible Programmable Timer

This block is an 8-bit up-counting timer that sits beside the execution unit of a 4-bit microcontroller core. The core controls it with single-cycle strobes. One strobe loads all eight bits from an instruction's immediate byte. Two strobes write one 4-bit nibble from the accumulator. Two more start and stop counting. The core reads the count back as two separate nibbles, so it never needs an 8-bit data path to the timer.

While counting is enabled, the counter advances once per prescaled tick. When it passes 0xFF, it reloads the value that was last written to it and raises a timeout flag. This gives a periodic time base without help from software. A conditional-jump unit tests the flag and pulses a clear strobe when the jump is taken. When the core allows it, the flag also drives an interrupt request.

Top module: `nib_timer`

## Requirements
- R1: After reset the count is 0x00, counting is stopped (`running` low) and `timeout` is low.
- R2: A pulse on `ldFullStb` sets the 8-bit count to `ldFullVal` on the next clock edge, with `cntHi` = bits 7:4 and `cntLo` = bits 3:0. The new count also becomes the reload value.
- R3: `wrLoStb` replaces only bits 3:0 of the count with `wrNibVal`, and `wrHiStb` replaces only bits 7:4. The other nibble keeps its value, and the resulting 8-bit count becomes the reload value.
- R4: `runOnStb` sets `running` and `runOffStb` clears it from the next edge; when both are pulsed together, `runOffStb` wins. While `running` is low, ticks leave the count unchanged. A tick that arrives in the same cycle as `runOnStb` is not counted.
- R5: While `running` is high, each cycle with `tick` high adds one to the count.
- R6: A counted tick at count 0xFF loads the reload value into the counter and sets `timeout`.
- R7: A pulse on `toClrStb` clears `timeout`, and so does any write (`ldFullStb`, `wrLoStb` or `wrHiStb`). If a rollover happens in the same cycle as `toClrStb`, `timeout` stays set.
- R8: A write in the same cycle as a counted tick takes priority. The count becomes the written value and is not incremented.
- R9: `irqReq` is high exactly when `timeout` and `irqEn` are both high. It follows `irqEn` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled count tick, one cycle wide |
| ldFullStb | input | 1 | Load all 8 bits from `ldFullVal` |
| ldFullVal | input | 8 | Immediate value for the 8-bit load |
| wrLoStb | input | 1 | Write `wrNibVal` into the low nibble |
| wrHiStb | input | 1 | Write `wrNibVal` into the high nibble |
| wrNibVal | input | 4 | Accumulator nibble for nibble writes |
| runOnStb | input | 1 | Start counting |
| runOffStb | input | 1 | Stop counting |
| toClrStb | input | 1 | Clear the timeout flag (jump taken) |
| irqEn | input | 1 | Interrupt enable from the core |
| cntLo | output | 4 | Low nibble of the count |
| cntHi | output | 4 | High nibble of the count |
| running | output | 1 | Counting enabled |
| timeout | output | 1 | Rollover has occurred since the last clear |
| irqReq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are collisions at the rollover edge: a tick at 0xFF in the same cycle as a flag clear, and a write in the same cycle as a counted tick. Both need the counter parked at a chosen value with counting enabled. The stimulus first loads 0xFF or another chosen value with a full load, then pulses the competing strobes in a single cycle. A full 256-tick run from 0x00 checks that wrap-around and the reload of zero work across the whole 8-bit range.

// File: rtl/ntimer_pkg.sv
package ntimer_pkg;
  parameter int CNT_W = 8;
  parameter int NIB_W = 4;
  localparam int NIBS = CNT_W / NIB_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic            ldFull;
    logic [NIBS-1:0] nibWr;
    logic            step;
    logic            wrap;
  } tmrCtl_t;
endpackage

// File: rtl/ntimer_ctl.sv
module ntimer_ctl
  import ntimer_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    ldFullStb,
  input  logic    wrLoStb,
  input  logic    wrHiStb,
  input  logic    runOnStb,
  input  logic    runOffStb,
  input  logic    toClrStb,
  input  logic    atMax,
  output tmrCtl_t ctl,
  output logic    running,
  output logic    timeout
);
  logic anyWr;
  logic counted;

  assign anyWr   = ldFullStb | wrLoStb | wrHiStb;
  assign counted = running & tick & ~anyWr;

  always_comb begin
    ctl = '0;
    ctl.ldFull        = ldFullStb;
    ctl.nibWr[0]      = wrLoStb;
    ctl.nibWr[NIBS-1] = wrHiStb;
    ctl.step          = counted & ~atMax;
    ctl.wrap          = counted & atMax;
  end

  // Run enable: stop wins over start
  always_ff @(posedge clk) begin
    if (!rstN)          running <= 1'b0;
    else if (runOffStb) running <= 1'b0;
    else if (runOnStb)  running <= 1'b1;
  end

  // Timeout flag: a rollover wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)                  timeout <= 1'b0;
    else if (ctl.wrap)          timeout <= 1'b1;
    else if (anyWr || toClrStb) timeout <= 1'b0;
  end

  a_r4_off_wins: assert property (@(posedge clk) disable iff (!rstN)
    runOffStb |=> !running);
  a_r4_on_starts: assert property (@(posedge clk) disable iff (!rstN)
    (runOnStb && !runOffStb) |=> running);
  a_r7_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    anyWr |=> !timeout);
  a_r6_wrap_sets: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrap |=> timeout);
endmodule

// File: rtl/ntimer_dp.sv
module ntimer_dp
  import ntimer_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int NW = NIB_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  tmrCtl_t       ctl,
  input  logic [CW-1:0] ldVal,
  input  logic [NW-1:0] nibVal,
  output logic [CW-1:0] cnt,
  output logic          atMax
);
  localparam int NN = CW / NW;

  logic [CW-1:0] reloadVal;
  logic [CW-1:0] wrVal;
  logic          doWr;

  assign atMax = (cnt == {CW{1'b1}});
  assign doWr  = ctl.ldFull | (|ctl.nibWr);

  // Merge writes: full load overrides nibble writes
  always_comb begin
    wrVal = cnt;
    for (int i = 0; i < NN; i++) begin
      if (ctl.nibWr[i]) wrVal[i*NW +: NW] = nibVal;
    end
    if (ctl.ldFull) wrVal = ldVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      reloadVal <= '0;
    end else if (doWr) begin
      cnt       <= wrVal;
      reloadVal <= wrVal;
    end else if (ctl.wrap) begin
      cnt       <= reloadVal;
    end else if (ctl.step) begin
      cnt       <= cnt + CW'(1);
    end
  end

  a_r2_full_load: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ldFull |=> cnt == $past(ldVal));
  a_r5_step: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> cnt == $past(cnt) + CW'(1));
  a_r6_wrap_at_max: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrap |-> cnt == {CW{1'b1}});
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!doWr && !ctl.step && !ctl.wrap) |=> $stable(cnt));
endmodule

// File: rtl/nib_timer.sv
module nib_timer
  import ntimer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             ldFullStb,
  input  logic [CNT_W-1:0] ldFullVal,
  input  logic             wrLoStb,
  input  logic             wrHiStb,
  input  logic [NIB_W-1:0] wrNibVal,
  input  logic             runOnStb,
  input  logic             runOffStb,
  input  logic             toClrStb,
  input  logic             irqEn,
  output logic [NIB_W-1:0] cntLo,
  output logic [NIB_W-1:0] cntHi,
  output logic             running,
  output logic             timeout,
  output logic             irqReq
);
  tmrCtl_t          ctl;
  logic             atMax;
  logic [CNT_W-1:0] cnt;

  ntimer_ctl uCtl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .ldFullStb(ldFullStb), .wrLoStb(wrLoStb), .wrHiStb(wrHiStb),
    .runOnStb(runOnStb), .runOffStb(runOffStb), .toClrStb(toClrStb),
    .atMax(atMax), .ctl(ctl), .running(running), .timeout(timeout)
  );

  ntimer_dp #(.CW(CNT_W), .NW(NIB_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .ldVal(ldFullVal), .nibVal(wrNibVal),
    .cnt(cnt), .atMax(atMax)
  );

  assign cntLo  = cnt[NIB_W-1:0];
  assign cntHi  = cnt[CNT_W-1:CNT_W-NIB_W];
  assign irqReq = timeout & irqEn;

  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (timeout && irqEn));
endmodule

// File: tb/tb_nib_timer.sv
module tb_nib_timer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN, tick, ldFullStb, wrLoStb, wrHiStb;
  logic       runOnStb, runOffStb, toClrStb, irqEn;
  logic [7:0] ldFullVal;
  logic [3:0] wrNibVal, cntLo, cntHi;
  logic       running, timeout, irqReq;

  nib_timer dut (
    .clk(clk), .rstN(rstN), .tick(tick),
    .ldFullStb(ldFullStb), .ldFullVal(ldFullVal),
    .wrLoStb(wrLoStb), .wrHiStb(wrHiStb), .wrNibVal(wrNibVal),
    .runOnStb(runOnStb), .runOffStb(runOffStb), .toClrStb(toClrStb),
    .irqEn(irqEn), .cntLo(cntLo), .cntHi(cntHi),
    .running(running), .timeout(timeout), .irqReq(irqReq)
  );

  int nChk  = 0;
  int nFail = 0;
  bit done  = 0;

  localparam int OP_LOAD = 0, OP_WRLO = 1, OP_WRHI = 2, OP_ON = 3;
  localparam int OP_OFF  = 4, OP_TICK = 5, OP_CLR  = 6, OP_IDLE = 7;

  // {op[2:0], data[7:0], expected count[7:0], expected timeout}
  localparam logic [19:0] VEC [0:12] = '{
    {3'd0, 8'hFC, 8'hFC, 1'b0},
    {3'd5, 8'h00, 8'hFC, 1'b0},
    {3'd3, 8'h00, 8'hFC, 1'b0},
    {3'd5, 8'h00, 8'hFD, 1'b0},
    {3'd5, 8'h00, 8'hFE, 1'b0},
    {3'd5, 8'h00, 8'hFF, 1'b0},
    {3'd5, 8'h00, 8'hFC, 1'b1},
    {3'd5, 8'h00, 8'hFD, 1'b1},
    {3'd6, 8'h00, 8'hFD, 1'b0},
    {3'd1, 8'h03, 8'hF3, 1'b0},
    {3'd2, 8'h0E, 8'hE3, 1'b0},
    {3'd4, 8'h00, 8'hE3, 1'b0},
    {3'd5, 8'h00, 8'hE3, 1'b0}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clrIn();
    tick = 0; ldFullStb = 0; wrLoStb = 0; wrHiStb = 0;
    runOnStb = 0; runOffStb = 0; toClrStb = 0;
    ldFullVal = '0; wrNibVal = '0;
  endtask

  task automatic setOp(int op, logic [7:0] d);
    case (op)
      OP_LOAD: begin ldFullStb = 1; ldFullVal = d; end
      OP_WRLO: begin wrLoStb = 1; wrNibVal = d[3:0]; end
      OP_WRHI: begin wrHiStb = 1; wrNibVal = d[3:0]; end
      OP_ON:   runOnStb = 1;
      OP_OFF:  runOffStb = 1;
      OP_TICK: tick = 1;
      OP_CLR:  toClrStb = 1;
      default: ;
    endcase
  endtask

  // Drive at the falling edge, let one rising edge pass, sample at the next falling edge
  task automatic cyc();
    @(negedge clk);
    clrIn();
  endtask

  task automatic doOp(int op, logic [7:0] d);
    setOp(op, d);
    cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    clrIn();
    irqEn = 0;
    rstN  = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    chk("R1 reset count", {cntHi, cntLo}, 8'h00);
    chk("R1 reset running", running, 0);
    chk("R1 reset timeout", timeout, 0);

    for (int i = 0; i < 13; i++) begin
      doOp(int'(VEC[i][19:17]), VEC[i][16:9]);
      chk($sformatf("R2 R3 R4 R5 R6 R7 vector %0d count", i), {cntHi, cntLo}, VEC[i][8:1]);
      chk($sformatf("R6 R7 vector %0d timeout", i), timeout, VEC[i][0]);
    end

    // R4: start and stop together, stop wins
    setOp(OP_ON, 0); setOp(OP_OFF, 0); cyc();
    chk("R4 off wins", running, 0);
    // R4: tick in the start cycle is not counted
    setOp(OP_ON, 0); setOp(OP_TICK, 0); cyc();
    chk("R4 running after on", running, 1);
    chk("R4 tick with on ignored", {cntHi, cntLo}, 8'hE3);

    // R8: a write beats a tick in the same cycle
    setOp(OP_TICK, 0); setOp(OP_WRLO, 8'h05); cyc();
    chk("R8 write beats tick", {cntHi, cntLo}, 8'hE5);
    doOp(OP_TICK, 0);
    chk("R5 step after write", {cntHi, cntLo}, 8'hE6);

    // R7: rollover and clear in the same cycle, flag stays set
    doOp(OP_LOAD, 8'hFF);
    setOp(OP_TICK, 0); setOp(OP_CLR, 0); cyc();
    chk("R6 reload of FF", {cntHi, cntLo}, 8'hFF);
    chk("R7 rollover beats clear", timeout, 1);

    // R9: the interrupt follows the enable combinationally
    chk("R9 irq masked", irqReq, 0);
    irqEn = 1; #1;
    chk("R9 irq raised", irqReq, 1);
    doOp(OP_CLR, 0);
    chk("R7 clear strobe", timeout, 0);
    chk("R9 irq drops with flag", irqReq, 0);

    // R6: full 256-tick period from zero
    doOp(OP_LOAD, 8'h00);
    for (int k = 0; k < 255; k++) doOp(OP_TICK, 0);
    chk("R5 count reaches FF", {cntHi, cntLo}, 8'hFF);
    chk("R6 no flag before wrap", timeout, 0);
    doOp(OP_TICK, 0);
    chk("R6 wrap reloads zero", {cntHi, cntLo}, 8'h00);
    chk("R6 flag on wrap", timeout, 1);
    chk("R9 irq on wrap", irqReq, 1);
    doOp(OP_WRHI, 8'h07);
    chk("R7 write clears flag", timeout, 0);
    chk("R3 high nibble only", {cntHi, cntLo}, 8'h70);

    // R1: reset in mid-run
    rstN = 0; cyc(); rstN = 1;
    chk("R1 rerun count", {cntHi, cntLo}, 8'h00);
    chk("R1 rerun running", running, 0);

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule